// File: doc/BRIEF.md
# AES-128 Encryption Core

This core encrypts one 128-bit block under a 128-bit key with the AES-128 cipher. A block and its key are presented together with `in_valid`, and the block is accepted on a rising clock edge where `in_ready` is also high. The ciphertext comes back on `out_text`, and `out_valid` is high for one cycle. Each block carries its own key, so the key may change on every block. Round keys are derived alongside the state as the block moves through the rounds. No expanded schedule is stored.

Two elaboration parameters trade area against speed without changing the result. `UNROLL` (1, 2, 5 or 10) sets how many round circuits are built in a chain. When the chain is shorter than ten rounds, a block travels around the loop 10/`UNROLL` times. `PIPE` (0 to 3) sets the registers per round: 0 gives no registers inside the chain, 1 gives one at the end of each round, and 2 or 3 split each round into that many stages. With `UNROLL`=10 and `PIPE`>0 the core is a free-running pipeline. In every other configuration it holds one block at a time and lowers `in_ready` while that block is in flight.

Top module: `aes128_enc`

## Requirements
- R1: With key 000102030405060708090a0b0c0d0e0f and plaintext 00112233445566778899aabbccddeeff (most significant byte first), `out_text` is 69c4e0d86a7b0430d8cdb78070b4c55a.
- R2: Key 2b7e151628aed2a6abf7158809cf4f3c with plaintext 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32. An all-zero key with an all-zero plaintext gives 66e94bd4ef8a2c3b884cfa59ca342b2e.
- R3: Each accepted block is encrypted under the key presented with it. This holds even when consecutive blocks use different keys. The result is the standard ten-round transform:
  - an initial key XOR;
  - nine rounds of byte substitution, row rotation (row r rotated left by r bytes), column mixing and round-key XOR;
  - a final round without column mixing.
- R4: With `UNROLL`=10 and `PIPE`>0, `in_ready` is high in every cycle after reset, so a block can be accepted on every edge.
- R5: In all other configurations, at most one block is in flight. `in_ready` goes low on the edge after an accept. It is high again in the cycle where that block's `out_valid` is high, and stays high until the next accept.
- R6: `out_valid` rises L edges after the accepting edge. L = 10·`PIPE` for the free-running pipeline. Otherwise L = (10/`UNROLL`)·(`UNROLL`·`PIPE`+1).
- R7: Every accepted block produces exactly one `out_valid` cycle, and results leave in acceptance order. `out_valid` is never high without an outstanding block.
- R8: In the cycle after reset is applied, `out_valid` is low. After reset, `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A block and key are presented |
| in_ready | output | 1 | The core can accept a block this cycle |
| in_key | input | 128 | Cipher key, byte 0 in bits 127:120 |
| in_text | input | 128 | Plaintext block, byte 0 in bits 127:120 |
| out_valid | output | 1 | One-cycle strobe: `out_text` holds a result |
| out_text | output | 128 | Ciphertext block |

## Verification
The assertions check the handshake on every cycle in the looping configurations:
- the single-block limit and the drop of `in_ready` after an accept;
- the return of `in_ready` with the result, and the exact loop latency, counted by a counter in the checker;
- that no result appears without an outstanding block.

Whether the ciphertext is correct can only be shown by the bench's scenarios. These are:
- the three fixed vectors;
- a sweep of pseudo-random keys and blocks against an arithmetic reference model, over five unroll and pipeline settings;
- back-to-back streaming with per-block key changes and idle gaps in the free-running pipeline, where latency and ordering are also measured.

// File: rtl/aes128_enc.sv
module aes128_enc #(
  parameter int UNROLL = 2,
  parameter int PIPE   = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_key,
  input  logic [127:0] in_text,
  output logic         out_valid,
  output logic [127:0] out_text
);
  localparam bit FULL = (UNROLL == 10) && (PIPE > 0);
  localparam int OPS  = 4 * UNROLL;

  typedef struct packed {
    logic         v;
    logic [3:0]   rnd;
    logic [127:0] rk;
    logic [127:0] st;
  } bundle_t;

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] a);
    logic [7:0] t, r;
    t = a;
    r = 8'h01;
    for (int i = 1; i < 8; i++) begin
      t = gmul(t, t);
      r = gmul(r, t);
    end
    return r ^ {r[6:0], r[7]} ^ {r[5:0], r[7:6]} ^ {r[4:0], r[7:5]} ^ {r[3:0], r[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [7:0] rcon(input logic [3:0] n);
    logic [7:0] r;
    r = 8'h01;
    for (int i = 1; i < 10; i++)
      if (4'(i) < n) r = xt(r);
    return r;
  endfunction

  function automatic logic [127:0] next_key(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] w0, w1, w2, w3, t;
    {w0, w1, w2, w3} = k;
    t  = {sbox(w3[23:16]), sbox(w3[15:8]), sbox(w3[7:0]), sbox(w3[31:24])} ^ {rc, 24'h0};
    w0 = w0 ^ t;
    w1 = w1 ^ w0;
    w2 = w2 ^ w1;
    w3 = w3 ^ w2;
    return {w0, w1, w2, w3};
  endfunction

  function automatic logic [127:0] sub_bytes(input logic [127:0] s);
    logic [127:0] o;
    for (int j = 0; j < 16; j++) o[8*j +: 8] = sbox(s[8*j +: 8]);
    return o;
  endfunction

  function automatic logic [127:0] shift_rows(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = s[127-8*(4*((c+r)%4)+r) -: 8];
    return o;
  endfunction

  function automatic logic [127:0] mix_cols(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      {a0, a1, a2, a3} = s[127-32*c -: 32];
      o[127-32*c -: 32] = {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
                           a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
                           a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
                           xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
    end
    return o;
  endfunction

  function automatic bundle_t step(input bundle_t b, input int op);
    bundle_t o;
    o = b;
    case (op)
      0: begin
        o.st = sub_bytes(b.st);
        o.rk = next_key(b.rk, rcon(b.rnd));
      end
      1: o.st = shift_rows(b.st);
      2: if (b.rnd != 4'd10) o.st = mix_cols(b.st);
      default: begin
        o.st  = b.st ^ b.rk;
        o.rnd = b.rnd + 4'd1;
      end
    endcase
    return o;
  endfunction

  function automatic bit regd(input int p, input int op);
    return (p == 1 && op == 3) || (p == 2 && (op == 1 || op == 3)) || (p == 3 && op != 1);
  endfunction

  bundle_t init_b, lp_b, tail;
  bundle_t node [OPS+1];
  logic    busy, done;

  assign in_ready = FULL ? 1'b1 : !busy;
  assign init_b   = {in_valid && in_ready, 4'd1, in_key, in_text ^ in_key};
  assign node[0]  = FULL ? init_b : lp_b;
  assign tail     = node[OPS];
  assign done     = tail.v && (tail.rnd == 4'd11);

  for (genvar g = 0; g < OPS; g++) begin : g_op
    bundle_t nxt;
    assign nxt = step(node[g], g % 4);
    if (regd(PIPE, g % 4)) begin : g_reg
      bundle_t q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
      end
      assign node[g+1] = q;
    end else begin : g_wire
      assign node[g+1] = nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      lp_b      <= '0;
      out_valid <= 1'b0;
      out_text  <= '0;
    end else begin
      out_valid <= done;
      if (done) out_text <= tail.st;
      if (!FULL) begin
        if (in_valid && in_ready) begin
          lp_b <= init_b;
          busy <= 1'b1;
        end else if (tail.v && !done) begin
          lp_b <= tail;
        end else begin
          lp_b.v <= 1'b0;
        end
        if (done) busy <= 1'b0;
      end
    end
  end
endmodule

module aes128_enc_chk #(
  parameter int UNROLL = 2,
  parameter int PIPE   = 1
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid
);
  localparam bit FULL = (UNROLL == 10) && (PIPE > 0);
  localparam int LAT  = FULL ? 10 * PIPE : (10 / UNROLL) * (UNROLL * PIPE + 1);

  logic       acc;
  logic [7:0] pend, lat_cnt;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= '0;
      lat_cnt <= '0;
    end else begin
      pend <= pend + {7'd0, acc} - {7'd0, out_valid};
      if (acc) lat_cnt <= 8'd1;
      else if (lat_cnt != 8'hff) lat_cnt <= lat_cnt + 8'd1;
    end
  end

  AST_OUT_HAS_OWNER: assert property (@(posedge clk) disable iff (rst) out_valid |-> pend != 8'd0); // R7
  AST_ITER_PULSE: assert property (@(posedge clk) disable iff (rst) (!FULL && out_valid) |=> !out_valid); // R7
  AST_ITER_ONE_BLOCK: assert property (@(posedge clk) disable iff (rst) !FULL |-> pend <= 8'd1); // R5
  AST_ITER_BUSY: assert property (@(posedge clk) disable iff (rst) (!FULL && acc) |=> !in_ready); // R5
  AST_ITER_FREE: assert property (@(posedge clk) disable iff (rst) (!FULL && out_valid) |-> in_ready); // R5
  AST_ITER_LATENCY: assert property (@(posedge clk) disable iff (rst) (!FULL && out_valid) |-> lat_cnt == 8'(LAT + 1)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !out_valid); // R8
endmodule

bind aes128_enc aes128_enc_chk #(.UNROLL(UNROLL), .PIPE(PIPE)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid)
);

// File: tb/tb_aes128_enc.sv
`timescale 1ns/1ps
module tb_lane #(
  parameter int U = 1,
  parameter int P = 0,
  parameter int N = 24
) (
  input  logic clk,
  input  logic rst,
  output int   checks,
  output int   fails,
  output logic finished
);
  localparam bit FULL = (U == 10) && (P > 0);
  localparam int L    = FULL ? 10 * P : (10 / U) * (U * P + 1);

  logic         in_valid, in_ready, out_valid;
  logic [127:0] in_key, in_text, out_text;

  aes128_enc #(.UNROLL(U), .PIPE(P)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_key(in_key), .in_text(in_text), .out_valid(out_valid), .out_text(out_text)
  );

  logic [7:0]   sb [256];
  logic [127:0] keys [N];
  logic [127:0] pts  [N];
  logic [127:0] exps [N];
  int           acc_cyc [N];
  int           acc, rcv;
  int           cyc = 0;
  bit           first;
  bit [31:0]    rs;

  function automatic bit [7:0] r_xt(input bit [7:0] a);
    return a[7] ? ((a << 1) ^ 8'h1b) : (a << 1);
  endfunction

  function automatic bit [7:0] r_mul(input bit [7:0] a, input bit [7:0] b);
    bit [7:0] acc_v, aa, bb;
    acc_v = 0; aa = a; bb = b;
    while (bb != 0) begin
      if (bb[0]) acc_v ^= aa;
      aa = r_xt(aa);
      bb = bb >> 1;
    end
    return acc_v;
  endfunction

  function automatic string tag(input int i);
    if (i == 0) return "R1";
    if (i < 3) return "R2";
    return "R3";
  endfunction

  function automatic logic [127:0] ref_enc(input logic [127:0] key, input logic [127:0] pt);
    logic [31:0] w [44];
    logic [7:0]  b [16];
    logic [7:0]  t [16];
    logic [31:0] tw;
    logic [7:0]  rc;
    logic [127:0] o;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      tw = w[i-1];
      if (i % 4 == 0) begin
        tw = {sb[tw[23:16]], sb[tw[15:8]], sb[tw[7:0]], sb[tw[31:24]]} ^ {rc, 24'h0};
        rc = r_xt(rc);
      end
      w[i] = w[i-4] ^ tw;
    end
    for (int j = 0; j < 16; j++) b[j] = pt[127-8*j -: 8] ^ key[127-8*j -: 8];
    for (int rd = 1; rd <= 10; rd++) begin
      for (int j = 0; j < 16; j++) b[j] = sb[b[j]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[4*c+r] = b[4*((c+r)%4)+r];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          if (rd < 10)
            b[4*c+r] = r_mul(8'h02, t[4*c+r]) ^ r_mul(8'h03, t[4*c+(r+1)%4])
                     ^ t[4*c+(r+2)%4] ^ t[4*c+(r+3)%4];
          else
            b[4*c+r] = t[4*c+r];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) b[4*c+r] ^= w[4*rd+c][31-8*r -: 8];
    end
    for (int j = 0; j < 16; j++) o[127-8*j -: 8] = b[j];
    return o;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    bit [7:0] inv;
    finished = 0;
    in_valid = 0;
    in_key   = '0;
    in_text  = '0;
    for (int x = 0; x < 256; x++) begin
      inv = 0;
      for (int v = 1; v < 256; v++) if (r_mul(8'(x), 8'(v)) == 8'h01) inv = 8'(v);
      for (int i = 0; i < 8; i++)
        sb[x][i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8] ^ ((8'h63 >> i) & 1);
    end
    keys[0] = 128'h000102030405060708090a0b0c0d0e0f;
    pts[0]  = 128'h00112233445566778899aabbccddeeff;
    exps[0] = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
    keys[1] = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    pts[1]  = 128'h3243f6a8885a308d313198a2e0370734;
    exps[1] = 128'h3925841d02dc09fbdc118597196a0b32;
    keys[2] = '0;
    pts[2]  = '0;
    exps[2] = 128'h66e94bd4ef8a2c3b884cfa59ca342b2e;
    rs = 32'h1234_5678 ^ 32'(U * 77 + P);
    for (int i = 3; i < N; i++) begin
      for (int k = 0; k < 8; k++) begin
        rs ^= rs << 13; rs ^= rs >> 17; rs ^= rs << 5;
        if (k < 4) keys[i][32*k +: 32] = rs;
        else       pts[i][32*(k-4) +: 32] = rs;
      end
      exps[i] = ref_enc(keys[i], pts[i]);
    end
    wait (rst === 1'b0);
    @(posedge clk); #1;
    for (int i = 0; i < N; i++) begin
      if (i % 5 == 3)
        repeat (i % 3 + 1) begin
          in_valid = 0;
          @(posedge clk); #1;
        end
      in_valid = 1;
      in_key   = keys[i];
      in_text  = pts[i];
      do @(posedge clk); while (acc <= i);
      #1;
    end
    in_valid = 0;
    wait (rcv == N);
    finished = 1;
  end

  always @(negedge clk) begin
    if (rst) begin
      checks = 0; fails = 0; acc = 0; rcv = 0; first = 1;
    end else begin
      if (first) begin
        first = 0;
        checks++;
        if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
          fails++;
          $display("FAIL R8 U=%0d P=%0d out_valid=%b in_ready=%b exp 0 1", U, P, out_valid, in_ready);
        end
      end
      if (out_valid) begin
        checks++;
        if (rcv >= acc) begin
          fails++;
          $display("FAIL R7 U=%0d P=%0d result with no outstanding block: got %0d results exp <= %0d", U, P, rcv + 1, acc);
        end else begin
          if (out_text !== exps[rcv]) begin
            fails++;
            $display("FAIL %s U=%0d P=%0d block %0d got %h exp %h", tag(rcv), U, P, rcv, out_text, exps[rcv]);
          end
          checks++;
          if (cyc - acc_cyc[rcv] != L + 1) begin
            fails++;
            $display("FAIL R6 U=%0d P=%0d block %0d latency got %0d exp %0d", U, P, rcv, cyc - acc_cyc[rcv] - 1, L);
          end
        end
        rcv++;
      end
      checks++;
      if (FULL && in_ready !== 1'b1) begin
        fails++;
        $display("FAIL R4 U=%0d P=%0d in_ready got %b exp 1", U, P, in_ready);
      end else if (!FULL && in_ready !== (acc == rcv)) begin
        fails++;
        $display("FAIL R5 U=%0d P=%0d in_ready got %b exp %b", U, P, in_ready, acc == rcv);
      end
      if (in_valid && in_ready && acc < N) begin
        acc_cyc[acc] = cyc;
        acc++;
      end
    end
  end
endmodule

module tb_aes128_enc;
  logic clk = 0;
  logic rst = 1;
  always #2.5 clk = ~clk;

  int   c0, c1, c2, c3, c4, e0, e1, e2, e3, e4;
  logic f0, f1, f2, f3, f4;

  tb_lane #(.U(1),  .P(0)) lane_a (.clk(clk), .rst(rst), .checks(c0), .fails(e0), .finished(f0));
  tb_lane #(.U(2),  .P(1)) lane_b (.clk(clk), .rst(rst), .checks(c1), .fails(e1), .finished(f1));
  tb_lane #(.U(5),  .P(3)) lane_c (.clk(clk), .rst(rst), .checks(c2), .fails(e2), .finished(f2));
  tb_lane #(.U(10), .P(0)) lane_d (.clk(clk), .rst(rst), .checks(c3), .fails(e3), .finished(f3));
  tb_lane #(.U(10), .P(2)) lane_e (.clk(clk), .rst(rst), .checks(c4), .fails(e4), .finished(f4));

  initial begin
    int wd, extra_c, extra_f;
    extra_c = 0;
    extra_f = 0;
    repeat (5) @(posedge clk);
    #1 rst = 0;
    wd = 0;
    while (!(f0 && f1 && f2 && f3 && f4) && wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    if (wd >= 100000) begin
      extra_c = 1;
      extra_f = 1;
      $display("FAIL R7 watchdog: got %0b%0b%0b%0b%0b lanes finished exp 11111", f0, f1, f2, f3, f4);
    end
    #1;
    $display("== %0d vectors applied, %0d miscompares ==",
             c0 + c1 + c2 + c3 + c4 + extra_c, e0 + e1 + e2 + e3 + e4 + extra_f);
    $finish;
  end
endmodule